// File: doc/BRIEF.md
# Single-Wire Bus Slot Timing Engine

This block produces the timed slots of a single-wire, open-drain serial bus. It offers three slot kinds on command: a bus reset with presence detection, a plain write slot, and a touch slot. A touch of 1 is a read: the engine pulls the line low briefly, releases it and samples the level the device leaves on the line. A touch of 0 is a write-0 slot that returns 0. The engine only ever pulls the line low or lets it go. An external resistor pulls it high.

Time is kept in microseconds. A divider derives them from the system clock, using the parameter `CLK_PER_US`. Each phase length is a fixed number of microseconds multiplied by a per-slot scale factor, which is captured when the slot starts. The incoming line level passes through a synchronizer. The sample time is shifted by the synchronizer latency, so the captured value is the line level at the nominal sample instant.

A controller raises `start` for one clock with the slot kind, the write bit and the scale. It then waits for `done`. Byte framing, ROM search, CRC and strong pull-up drive are handled outside this block.

Top module: `owire_slot_engine`

## Requirements
- R1: After reset, `busy`, `done`, `line_pull_low`, `rx_bit` and `present` are all 0.
- R2: A write slot (`slot_kind` = 1) with `wr_bit` = 1 pulls the line low for 6 µs. It then releases the line, and `done` rises 70 µs after the start edge.
- R3: A write slot with `wr_bit` = 0 pulls the line low for 60 µs. It then releases the line, and `done` rises 70 µs after the start edge.
- R4: A touch slot (`slot_kind` = 2) with `wr_bit` = 1 pulls the line low for 6 µs and then releases it. It samples the line 9 µs after the release and ends 70 µs after the start edge. `rx_bit` takes the sampled level, which is the line level during the last clock before the sample instant.
- R5: A touch slot with `wr_bit` = 0 has the timing of R3 and sets `rx_bit` to 0.
- R6: A reset slot (`slot_kind` = 0) pulls the line low for 480 µs and samples the line 70 µs after the release. It ends 960 µs after the start edge. `present` is 1 when the sampled line was low and 0 when it was high.
- R7: Every phase length equals its microsecond count times `scale` times `CLK_PER_US` clocks. A `scale` of 0 acts as 1.
- R8: A `start` pulse that arrives while `busy` is 1 has no effect on the running slot.
- R9: `done` is high for exactly one clock, on the same edge at which `busy` falls.
- R10: A `start` pulse with `slot_kind` = 3 starts no slot. `busy` and `line_pull_low` stay 0.
- R11: Write slots leave `rx_bit` and `present` unchanged. Touch slots leave `present` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock request to begin a slot |
| slot_kind | input | 2 | 0 reset, 1 write, 2 touch, 3 no slot |
| wr_bit | input | 1 | Bit to write or touch |
| scale | input | SCALE_W | Delay multiplier captured at start (0 acts as 1) |
| line_in | input | 1 | Level of the bus line |
| line_pull_low | output | 1 | 1 drives the open-drain line low |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-clock pulse at slot end |
| rx_bit | output | 1 | Result of the last touch slot |
| present | output | 1 | Presence result of the last reset slot |

## Verification
Each slot kind is run with a modelled device that holds the line low for a chosen time after the engine releases it. Hold times just shorter and just longer than the sample offset show whether the sample lands at the right microsecond, not at the release and not at the slot end. The same slots are repeated with scales 0, 2 and 3, which separates a fixed timer from a scaled one. Extra start pulses during a slot and with the unused slot code show that stray requests are ignored.

// File: rtl/owire_pkg.sv
package owire_pkg;

  typedef enum logic [1:0] {
    KIND_RESET = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_TOUCH = 2'd2,
    KIND_NONE  = 2'd3
  } slot_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_MID,
    PH_TAIL
  } phase_e;

  // phase lengths in microseconds before scaling
  localparam int unsigned RST_LOW_US  = 480;
  localparam int unsigned RST_SMP_US  = 70;
  localparam int unsigned RST_TAIL_US = 410;
  localparam int unsigned ONE_LOW_US  = 6;
  localparam int unsigned ONE_REC_US  = 64;
  localparam int unsigned ZERO_LOW_US = 60;
  localparam int unsigned ZERO_REC_US = 10;
  localparam int unsigned RD_SMP_US   = 9;
  localparam int unsigned RD_TAIL_US  = 55;

  localparam int unsigned DUR_W = $clog2(RST_LOW_US + 1);

endpackage

// File: rtl/owire_us_tick.sv
module owire_us_tick #(
  parameter int unsigned CLK_PER_US = 125,
  parameter int unsigned HIT_AT     = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick,
  output logic lag_hit
);
  localparam int unsigned CNT_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_PER_US - 1);
  localparam logic [CNT_W-1:0] HIT  = CNT_W'(HIT_AT);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick    = run && (cnt == LAST);
  assign lag_hit = run && (cnt == HIT);

  // ticks are spaced a full microsecond apart
  p_tick_spacing_r7: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/owire_line_sync.sv
module owire_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/owire_slot_seq.sv
module owire_slot_seq
  import owire_pkg::*;
#(
  parameter int unsigned SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [1:0]         kind,
  input  logic               wbit,
  input  logic [SCALE_W-1:0] scale,
  input  logic               tick,
  input  logic               lag_hit,
  input  logic               line_s,
  output logic               busy,
  output logic               pull_low,
  output logic               done,
  output logic               rx_bit,
  output logic               present
);
  localparam int unsigned LEN_W = DUR_W + SCALE_W;

  phase_e             ph, ph_n;
  slot_kind_e         kind_q;
  logic               bit_q, smp_q;
  logic [SCALE_W-1:0] scale_q;
  logic [LEN_W-1:0]   us_cnt, len;
  logic [DUR_W-1:0]   base;
  logic               accept, ph_end, take_sample;

  assign accept = (ph == PH_IDLE) && start && (slot_kind_e'(kind) != KIND_NONE);

  always_comb begin
    base = '0;
    unique case (ph)
      PH_LOW:  base = (kind_q == KIND_RESET) ? DUR_W'(RST_LOW_US)
                    : (bit_q ? DUR_W'(ONE_LOW_US) : DUR_W'(ZERO_LOW_US));
      PH_MID:  base = (kind_q == KIND_RESET) ? DUR_W'(RST_SMP_US)
                    : smp_q ? DUR_W'(RD_SMP_US)
                    : (bit_q ? DUR_W'(ONE_REC_US) : DUR_W'(ZERO_REC_US));
      PH_TAIL: base = (kind_q == KIND_RESET) ? DUR_W'(RST_TAIL_US) : DUR_W'(RD_TAIL_US);
      default: base = '0;
    endcase
  end

  assign len         = LEN_W'(base) * LEN_W'(scale_q);
  assign ph_end      = tick && (us_cnt == len - LEN_W'(1));
  assign take_sample = (ph == PH_TAIL) && (us_cnt == '0) && lag_hit;

  always_comb begin
    ph_n = ph;
    unique case (ph)
      PH_IDLE: if (accept) ph_n = PH_LOW;
      PH_LOW:  if (ph_end) ph_n = PH_MID;
      PH_MID:  if (ph_end) ph_n = smp_q ? PH_TAIL : PH_IDLE;
      PH_TAIL: if (ph_end) ph_n = PH_IDLE;
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      kind_q   <= KIND_WRITE;
      bit_q    <= 1'b0;
      smp_q    <= 1'b0;
      scale_q  <= SCALE_W'(1);
      us_cnt   <= '0;
      busy     <= 1'b0;
      pull_low <= 1'b0;
      done     <= 1'b0;
      rx_bit   <= 1'b0;
      present  <= 1'b0;
    end else begin
      ph       <= ph_n;
      busy     <= (ph_n != PH_IDLE);
      pull_low <= (ph_n == PH_LOW);
      done     <= (ph != PH_IDLE) && (ph_n == PH_IDLE);
      if (accept) begin
        kind_q  <= slot_kind_e'(kind);
        bit_q   <= wbit;
        smp_q   <= (slot_kind_e'(kind) == KIND_RESET) ||
                   ((slot_kind_e'(kind) == KIND_TOUCH) && wbit);
        scale_q <= (scale == '0) ? SCALE_W'(1) : scale;
        if ((slot_kind_e'(kind) == KIND_TOUCH) && !wbit) rx_bit <= 1'b0;
      end
      if (ph == PH_IDLE || ph_end) us_cnt <= '0;
      else if (tick)               us_cnt <= us_cnt + 1'b1;
      if (take_sample) begin
        if (kind_q == KIND_RESET) present <= !line_s;
        else                      rx_bit  <= line_s;
      end
    end
  end

  p_done_one_clk_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_busy_fall_done_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  p_idle_released_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !pull_low);
  p_slot_opens_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> pull_low);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(kind_q) && $stable(scale_q) && $stable(bit_q)));
  p_presence_kept_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && kind_q != KIND_RESET) |=> $stable(present));

endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine #(
  parameter int unsigned CLK_PER_US  = 125,
  parameter int unsigned SCALE_W     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [1:0]         slot_kind,
  input  logic               wr_bit,
  input  logic [SCALE_W-1:0] scale,
  input  logic               line_in,
  output logic               line_pull_low,
  output logic               busy,
  output logic               done,
  output logic               rx_bit,
  output logic               present
);
  // the sample is read SYNC_STAGES clocks after the nominal instant
  localparam int unsigned HIT_AT = SYNC_STAGES - 1;

  logic tick, lag_hit, line_s;

  owire_us_tick #(
    .CLK_PER_US (CLK_PER_US),
    .HIT_AT     (HIT_AT)
  ) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .tick    (tick),
    .lag_hit (lag_hit)
  );

  owire_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (line_in),
    .dout (line_s)
  );

  owire_slot_seq #(
    .SCALE_W (SCALE_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .kind     (slot_kind),
    .wbit     (wr_bit),
    .scale    (scale),
    .tick     (tick),
    .lag_hit  (lag_hit),
    .line_s   (line_s),
    .busy     (busy),
    .pull_low (line_pull_low),
    .done     (done),
    .rx_bit   (rx_bit),
    .present  (present)
  );

endmodule

// File: tb/test_owire_slot_engine.sv
module test_owire_slot_engine;
  localparam int P  = 4;
  localparam int SW = 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, wbit = 1'b0, dev_low = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [SW-1:0] scale = 1;
  logic pull, busy, done, rx_bit, present, line;

  assign line = !(pull || dev_low);
  always #4 clk = ~clk;

  owire_slot_engine #(.CLK_PER_US(P), .SCALE_W(SW), .SYNC_STAGES(2)) i_owire_slot_engine (
    .clk(clk), .rst(rst), .start(start), .slot_kind(kind), .wr_bit(wbit),
    .scale(scale), .line_in(line), .line_pull_low(pull), .busy(busy),
    .done(done), .rx_bit(rx_bit), .present(present));

  typedef struct {
    int    low;
    int    total;
    bit    do_rx;
    bit    rx;
    bit    do_pr;
    bit    pr;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  int hold_cfg = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // device model: holds the line low for hold_cfg clocks after the engine releases it
  int  hold_left = 0;
  bit  prev_pull = 1'b0;
  always @(negedge clk) begin
    if (prev_pull && !pull && hold_cfg > 0) begin
      dev_low   = 1'b1;
      hold_left = hold_cfg;
    end else if (hold_left > 0) begin
      hold_left--;
      if (hold_left == 0) dev_low = 1'b0;
    end
    prev_pull = pull;
  end

  // monitor: measures each slot and compares it with the queued expectation
  int low_cnt = 0, busy_cnt = 0;
  bit prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pull) low_cnt++;
      if (busy) busy_cnt++;
      if (done) begin
        exp_t e;
        check(!prev_done, "R9", "done width", 2, 1);
        check(!busy, "R9", "busy at done", int'(busy), 0);
        if (q.size() == 0) begin
          check(1'b0, "R8", "unexpected slot end", 1, 0);
        end else begin
          e = q.pop_front();
          check(low_cnt == e.low, e.req, "low clocks", low_cnt, e.low);
          check(busy_cnt == e.total, e.req, "slot clocks", busy_cnt, e.total);
          if (e.do_rx) check(rx_bit == e.rx, e.req, "rx_bit", int'(rx_bit), int'(e.rx));
          if (e.do_pr) check(present == e.pr, e.req, "present", int'(present), int'(e.pr));
        end
        low_cnt  = 0;
        busy_cnt = 0;
      end
      prev_done = done;
    end
  end

  // driver: pushes the expectation, then issues the slot
  task automatic run_slot(input int k, input bit b, input int sc, input int hold_us,
                          input bit do_rx, input bit erx, input bit do_pr, input bit epr,
                          input bit poke, input string req);
    exp_t e;
    int eff = (sc == 0) ? 1 : sc;
    int lo, mid, tl;
    if (k == 0)      begin lo = 480; mid = 70; tl = 410; end
    else if (k == 2 && b) begin lo = 6; mid = 9; tl = 55; end
    else if (b)      begin lo = 6; mid = 64; tl = 0; end
    else             begin lo = 60; mid = 10; tl = 0; end
    e.low   = lo * eff * P;
    e.total = (lo + mid + tl) * eff * P;
    e.do_rx = do_rx; e.rx = erx; e.do_pr = do_pr; e.pr = epr; e.req = req;
    q.push_back(e);
    hold_cfg = hold_us * eff * P;
    @(negedge clk);
    kind = 2'(k); wbit = b; scale = SW'(sc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      kind = 2'd0; wbit = 1'b0; scale = 4'd15; start = 1'b1;   // R8 stray request
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    hold_cfg = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", "timeout", 1, 0);
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1", "busy", int'(busy), 0);
    check(done == 0, "R1", "done", int'(done), 0);
    check(pull == 0, "R1", "line_pull_low", int'(pull), 0);
    check(rx_bit == 0, "R1", "rx_bit", int'(rx_bit), 0);
    check(present == 0, "R1", "present", int'(present), 0);

    // R2, R3 write slots, R11 rx untouched
    run_slot(1, 1, 1, 0, 1, 0, 1, 0, 0, "R2");
    run_slot(1, 0, 1, 0, 1, 0, 1, 0, 0, "R3");
    // R4 touch-1 with varied device hold times around the sample point
    run_slot(2, 1, 1, 0,  1, 1, 0, 0, 0, "R4");
    run_slot(2, 1, 1, 10, 1, 0, 0, 0, 0, "R4");
    run_slot(2, 1, 1, 8,  1, 1, 0, 0, 0, "R4");
    // R11 write leaves rx_bit=1
    run_slot(1, 0, 1, 0, 1, 1, 1, 0, 0, "R11");
    // R5 touch-0 returns 0
    run_slot(2, 0, 1, 0, 1, 0, 0, 0, 0, "R5");
    // R6 resets with and without a presence pulse
    run_slot(0, 0, 1, 100, 0, 0, 1, 1, 0, "R6");
    run_slot(0, 0, 1, 69,  0, 0, 1, 0, 0, "R6");
    run_slot(0, 0, 1, 71,  0, 0, 1, 1, 0, "R6");
    // R11 touch keeps present=1
    run_slot(2, 1, 1, 0, 1, 1, 1, 1, 0, "R11");
    // R7 scaling, scale 0 acts as 1
    run_slot(1, 1, 2, 0,  1, 1, 1, 1, 0, "R7");
    run_slot(1, 0, 0, 0,  1, 1, 1, 1, 0, "R7");
    run_slot(2, 1, 3, 20, 1, 0, 1, 1, 0, "R7");
    run_slot(2, 1, 3, 8,  1, 1, 1, 1, 0, "R7");
    // R8 stray start during a slot
    run_slot(1, 1, 1, 0, 1, 1, 1, 1, 1, "R8");

    // R10 unused slot code starts nothing
    @(negedge clk);
    kind = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(busy == 0, "R10", "busy", int'(busy), 0);
      check(pull == 0, "R10", "line_pull_low", int'(pull), 0);
    end
    check(q.size() == 0, "R8", "pending slots", q.size(), 0);
    finish_up();
  end

endmodule